// File: doc/BRIEF.md
# Selectable-Rate Waveform Sample Capture

This block takes snapshots of internal sample streams at a programmable rate. A free-running divider on the master clock makes an update strobe. The period is 128, 256, 512 or 1024 clocks, set by a 2-bit rate field. On each strobe the block copies the value picked by a 2-bit source field into a held waveform register. It reports the length of that value (24 or 40 bits) and raises a one-clock data-ready pulse.

The source field chooses between the filtered active power value, the channel 1 sample, the channel 2 sample, and a packed 40-bit word that carries both channels reduced to 20 bits each. In the wider system the two fields are bits 12:11 (rate) and 14:13 (source) of a mode word. That word is decoded outside this block, and the fields arrive here as separate ports. Whenever the rate field changes, the divider restarts, so the first capture at the new rate comes one full new period later.

Top module: `wave_capture`

## Requirements
- R1: While reset is asserted (active-low, asynchronous), `wave_reg`, `wave_len` and `wave_rdy` are all zero. After release, with the rate field at 00, the first data-ready pulse is seen after the 128th rising edge.
- R2: With the rate field held steady, consecutive data-ready pulses are exactly P clocks apart, where P is 128 for code 00, 256 for 01, 512 for 10 and 1024 for 11.
- R3: When the rate field changes, the divider restarts. Counting the first rising edge that samples the new code as edge 1, the next data-ready pulse is seen after edge P+1, where P is the new period.
- R4: `wave_rdy` is high for exactly one clock per capture. `wave_reg` and `wave_len` change only in the cycle in which `wave_rdy` is high, and hold their values between captures even when the sample inputs change.
- R5: Source code 00 captures `pwr_smp` into `wave_reg[23:0]` with bits 39:24 zero, and `wave_len` reads 24.
- R6: Source code 10 captures `ch1_smp` and source code 11 captures `ch2_smp`, in both cases into bits 23:0 with bits 39:24 zero, and `wave_len` reads 24.
- R7: Source code 01 captures a 40-bit word with `ch1_smp[23:4]` in bits 39:20 and `ch2_smp[23:4]` in bits 19:0, and `wave_len` reads 40.
- R8: The captured value is the one selected by the source field sampled at the capture edge. A source change takes effect at the next strobe without restarting the divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_sel | input | 2 | Update-rate code (divide by 128·2^code) |
| src_sel | input | 2 | Source code: 00 power, 01 both channels, 10 channel 1, 11 channel 2 |
| pwr_smp | input | 24 | Filtered active power sample |
| ch1_smp | input | 24 | Channel 1 sample |
| ch2_smp | input | 24 | Channel 2 sample |
| wave_reg | output | 40 | Held waveform value |
| wave_len | output | 6 | Valid length of `wave_reg` in bits (24 or 40) |
| wave_rdy | output | 1 | One-clock pulse on each new capture |

## Verification
The bench builds the block with its default parameters: a base divide of 2^7, 24-bit samples, and 20-bit packed halves that keep the upper bits. With these values the real 128 to 1024 clock periods run within a short simulation, and every rate code and every source code can be reached. The 40-bit packing then has its defined truncation boundary at bit 4 of each channel, so the tests check both the exact restart latency after a rate change and the bit placement of the packed word.

// File: rtl/wcap_pkg.sv
package wcap_pkg;
   localparam int RATE_W = 2;
   localparam int SRC_W  = 2;

   typedef enum logic [SRC_W-1:0] {
      SRC_POWER = 2'b00,
      SRC_BOTH  = 2'b01,
      SRC_CH1   = 2'b10,
      SRC_CH2   = 2'b11
   } wcap_src_e;
endpackage

// File: rtl/wcap_rate_div.sv
module wcap_rate_div
   import wcap_pkg::*;
#(
   parameter int BASE_LOG2 = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [RATE_W-1:0] rate,
   output logic              strobe
);
   localparam int NRATE = 2 ** RATE_W;
   localparam int CNT_W = BASE_LOG2 + NRATE - 1;

   logic [CNT_W-1:0]  last_tbl [NRATE];
   logic [CNT_W-1:0]  cnt_q;
   logic [RATE_W-1:0] rate_q;
   logic              restart;
   logic              at_last;

   // terminal count for each rate code
   for (genvar gi = 0; gi < NRATE; gi++) begin : g_last
      assign last_tbl[gi] = CNT_W'((64'd1 << (BASE_LOG2 + gi)) - 64'd1);
   end

   assign restart = (rate != rate_q);
   assign at_last = (cnt_q == last_tbl[rate]);
   assign strobe  = !restart && at_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         rate_q <= '0;
      end else begin
         rate_q <= rate;
         if (restart || at_last) begin
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
         end
      end
   end
endmodule

// File: rtl/wcap_src_sel.sv
module wcap_src_sel
   import wcap_pkg::*;
#(
   parameter int SAMPLE_W = 24,
   parameter int PACK_W   = 20,
   parameter bit KEEP_MSB = 1'b1,
   parameter int WAVE_W   = 40,
   parameter int LEN_W    = 6
) (
   input  logic [SRC_W-1:0]    src,
   input  logic [SAMPLE_W-1:0] pwr,
   input  logic [SAMPLE_W-1:0] ch1,
   input  logic [SAMPLE_W-1:0] ch2,
   output logic [WAVE_W-1:0]   word,
   output logic [LEN_W-1:0]    len
);
   logic [PACK_W-1:0] ch1_cut;
   logic [PACK_W-1:0] ch2_cut;

   if (KEEP_MSB) begin : g_keep_msb
      assign ch1_cut = ch1[SAMPLE_W-1 -: PACK_W];
      assign ch2_cut = ch2[SAMPLE_W-1 -: PACK_W];
   end else begin : g_keep_lsb
      assign ch1_cut = ch1[PACK_W-1:0];
      assign ch2_cut = ch2[PACK_W-1:0];
   end

   always_comb begin
      word = WAVE_W'(pwr);
      len  = LEN_W'(SAMPLE_W);
      case (wcap_src_e'(src))
         SRC_POWER: begin
            word = WAVE_W'(pwr);
            len  = LEN_W'(SAMPLE_W);
         end
         SRC_BOTH: begin
            word = WAVE_W'({ch1_cut, ch2_cut});
            len  = LEN_W'(2 * PACK_W);
         end
         SRC_CH1: begin
            word = WAVE_W'(ch1);
            len  = LEN_W'(SAMPLE_W);
         end
         SRC_CH2: begin
            word = WAVE_W'(ch2);
            len  = LEN_W'(SAMPLE_W);
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/wcap_hold.sv
module wcap_hold #(
   parameter int WAVE_W = 40,
   parameter int LEN_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strobe,
   input  logic [WAVE_W-1:0] word_in,
   input  logic [LEN_W-1:0]  len_in,
   output logic [WAVE_W-1:0] word_q,
   output logic [LEN_W-1:0]  len_q,
   output logic              rdy_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= '0;
         len_q  <= '0;
         rdy_q  <= 1'b0;
      end else begin
         rdy_q <= strobe;
         if (strobe) begin
            word_q <= word_in;
            len_q  <= len_in;
         end
      end
   end
endmodule

// File: rtl/wave_capture.sv
module wave_capture
   import wcap_pkg::*;
#(
   parameter int BASE_DIV_LOG2 = 7,
   parameter int SAMPLE_W      = 24,
   parameter int PACK_W        = 20,
   parameter bit KEEP_MSB      = 1'b1,
   localparam int WAVE_W       = (2 * PACK_W > SAMPLE_W) ? 2 * PACK_W : SAMPLE_W,
   localparam int LEN_W        = $clog2(WAVE_W + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [RATE_W-1:0]   rate_sel,
   input  logic [SRC_W-1:0]    src_sel,
   input  logic [SAMPLE_W-1:0] pwr_smp,
   input  logic [SAMPLE_W-1:0] ch1_smp,
   input  logic [SAMPLE_W-1:0] ch2_smp,
   output logic [WAVE_W-1:0]   wave_reg,
   output logic [LEN_W-1:0]    wave_len,
   output logic                wave_rdy
);
   if (PACK_W > SAMPLE_W) begin : g_bad_pack
      $error("PACK_W must not exceed SAMPLE_W");
   end
   if (BASE_DIV_LOG2 < 1 || BASE_DIV_LOG2 > 40) begin : g_bad_base
      $error("BASE_DIV_LOG2 out of range");
   end
   if (PACK_W < 1) begin : g_bad_width
      $error("PACK_W must be positive");
   end

   logic              strobe;
   logic [WAVE_W-1:0] sel_word;
   logic [LEN_W-1:0]  sel_len;

   wcap_rate_div #(
      .BASE_LOG2 (BASE_DIV_LOG2)
   ) u_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .rate   (rate_sel),
      .strobe (strobe)
   );

   wcap_src_sel #(
      .SAMPLE_W (SAMPLE_W),
      .PACK_W   (PACK_W),
      .KEEP_MSB (KEEP_MSB),
      .WAVE_W   (WAVE_W),
      .LEN_W    (LEN_W)
   ) u_sel (
      .src  (src_sel),
      .pwr  (pwr_smp),
      .ch1  (ch1_smp),
      .ch2  (ch2_smp),
      .word (sel_word),
      .len  (sel_len)
   );

   wcap_hold #(
      .WAVE_W (WAVE_W),
      .LEN_W  (LEN_W)
   ) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .strobe  (strobe),
      .word_in (sel_word),
      .len_in  (sel_len),
      .word_q  (wave_reg),
      .len_q   (wave_len),
      .rdy_q   (wave_rdy)
   );
endmodule

// File: rtl/wave_capture_chk.sv
module wave_capture_chk
   import wcap_pkg::*;
#(
   parameter int BASE_DIV_LOG2 = 7,
   parameter int SAMPLE_W      = 24,
   parameter int PACK_W        = 20,
   parameter bit KEEP_MSB      = 1'b1,
   parameter int WAVE_W        = 40,
   parameter int LEN_W         = 6
) (
   input logic                clk,
   input logic                rst_n,
   input logic [SRC_W-1:0]    src_sel,
   input logic [SAMPLE_W-1:0] ch2_smp,
   input logic [WAVE_W-1:0]   wave_reg,
   input logic [LEN_W-1:0]    wave_len,
   input logic                wave_rdy
);
   localparam int GAP_W   = BASE_DIV_LOG2 + 5;
   localparam int MIN_GAP = 2 ** BASE_DIV_LOG2;

   logic [GAP_W-1:0]    gap_q;
   logic                seen_q;
   logic [SAMPLE_W-1:0] ch2_cut;

   assign ch2_cut = KEEP_MSB ? (ch2_smp >> (SAMPLE_W - PACK_W))
                             : (ch2_smp & SAMPLE_W'((64'd1 << PACK_W) - 64'd1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_q  <= '0;
         seen_q <= 1'b0;
      end else if (wave_rdy) begin
         gap_q  <= GAP_W'(1);
         seen_q <= 1'b1;
      end else if (!(&gap_q)) begin
         gap_q <= gap_q + GAP_W'(1);
      end
   end

   p_rdy_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wave_rdy |=> !wave_rdy);

   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(wave_reg) |-> wave_rdy);

   p_len_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(wave_len) |-> wave_rdy);

   p_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wave_rdy && seen_q) |-> (gap_q >= GAP_W'(MIN_GAP)));

   p_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wave_rdy |-> (wave_len == (($past(src_sel) == SRC_BOTH) ? LEN_W'(2 * PACK_W)
                                                               : LEN_W'(SAMPLE_W))));

   p_wide_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wave_rdy && $past(src_sel) == SRC_BOTH) |->
         (SAMPLE_W'(wave_reg[PACK_W-1:0]) == $past(ch2_cut)));
endmodule

bind wave_capture wave_capture_chk #(
   .BASE_DIV_LOG2 (BASE_DIV_LOG2),
   .SAMPLE_W      (SAMPLE_W),
   .PACK_W        (PACK_W),
   .KEEP_MSB      (KEEP_MSB),
   .WAVE_W        (WAVE_W),
   .LEN_W         (LEN_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .src_sel  (src_sel),
   .ch2_smp  (ch2_smp),
   .wave_reg (wave_reg),
   .wave_len (wave_len),
   .wave_rdy (wave_rdy)
);

// File: tb/wave_capture_test.sv
module wave_capture_test;
   localparam int NV = 7;
   // rate, source, power, ch1, ch2
   localparam logic [1:0]  V_RATE [NV] = '{2'd0, 2'd1, 2'd2, 2'd3, 2'd0, 2'd1, 2'd1};
   localparam logic [1:0]  V_SRC  [NV] = '{2'd0, 2'd2, 2'd3, 2'd1, 2'd1, 2'd0, 2'd3};
   localparam logic [23:0] V_PWR  [NV] = '{24'h5A3C01, 24'h000001, 24'h7FFFFF, 24'h111111,
                                          24'h800000, 24'hC0FFEE, 24'h0F0F0F};
   localparam logic [23:0] V_CH1  [NV] = '{24'h123456, 24'hFEDCBA, 24'h00000F, 24'hABCDEF,
                                          24'hFFFFF0, 24'h2468AC, 24'h135790};
   localparam logic [23:0] V_CH2  [NV] = '{24'h654321, 24'h0000F0, 24'hA5A5A5, 24'h123456,
                                          24'h00000F, 24'h369CF0, 24'h8000FF};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  rate_sel = 2'd0;
   logic [1:0]  src_sel = 2'd0;
   logic [23:0] pwr_smp = '0;
   logic [23:0] ch1_smp = '0;
   logic [23:0] ch2_smp = '0;
   logic [39:0] wave_reg;
   logic [5:0]  wave_len;
   logic        wave_rdy;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   wave_capture #(
      .BASE_DIV_LOG2 (7),
      .SAMPLE_W      (24),
      .PACK_W        (20),
      .KEEP_MSB      (1'b1)
   ) uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .rate_sel (rate_sel),
      .src_sel  (src_sel),
      .pwr_smp  (pwr_smp),
      .ch1_smp  (ch1_smp),
      .ch2_smp  (ch2_smp),
      .wave_reg (wave_reg),
      .wave_len (wave_len),
      .wave_rdy (wave_rdy)
   );

   function automatic logic [39:0] exp_word(input logic [1:0] s, input logic [23:0] p,
                                            input logic [23:0] c1, input logic [23:0] c2);
      case (s)
         2'd0:    return {16'h0, p};
         2'd1:    return {c1[23:4], c2[23:4]};
         2'd2:    return {16'h0, c1};
         default: return {16'h0, c2};
      endcase
   endfunction

   function automatic string src_tag(input logic [1:0] s);
      case (s)
         2'd0:    return "R5";
         2'd1:    return "R7";
         default: return "R6";
      endcase
   endfunction

   task automatic check(input bit ok, input string tag, input logic [63:0] act,
                        input logic [63:0] expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, expv);
      end
   endtask

   task automatic wait_rdy(output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!wave_rdy && n < 3000);
      if (!wave_rdy) check(1'b0, "watchdog", 64'(n), 64'd0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      #(4 * 200000);
      check(1'b0, "watchdog", 64'd0, 64'd1);
      finish_run();
   end

   initial begin
      int n;
      int per;
      logic [1:0] prev_rate;
      logic [39:0] held;

      // R1: reset state
      repeat (3) @(negedge clk);
      check(wave_reg == '0 && wave_len == '0 && wave_rdy == 1'b0, "R1",
            {wave_reg, wave_len, 17'(wave_rdy)}, 64'd0);
      rst_n = 1'b1;
      wait_rdy(n);
      check(n == 128, "R1", 64'(n), 64'd128);
      prev_rate = 2'd0;

      for (int i = 0; i < NV; i++) begin
         per = 128 << V_RATE[i];
         @(negedge clk);
         rate_sel = V_RATE[i];
         src_sel  = V_SRC[i];
         pwr_smp  = V_PWR[i];
         ch1_smp  = V_CH1[i];
         ch2_smp  = V_CH2[i];
         wait_rdy(n);
         if (V_RATE[i] != prev_rate) begin
            check(n == per + 1, "R3", 64'(n), 64'(per + 1));
         end else begin
            // R8: source change took effect without restarting the divider
            check(n <= per, "R8", 64'(n), 64'(per));
         end
         check(wave_reg == exp_word(V_SRC[i], V_PWR[i], V_CH1[i], V_CH2[i]), src_tag(V_SRC[i]),
               64'(wave_reg), 64'(exp_word(V_SRC[i], V_PWR[i], V_CH1[i], V_CH2[i])));
         check(wave_len == ((V_SRC[i] == 2'd1) ? 6'd40 : 6'd24), src_tag(V_SRC[i]),
               64'(wave_len), 64'((V_SRC[i] == 2'd1) ? 40 : 24));
         held = wave_reg;
         @(negedge clk);
         check(wave_rdy == 1'b0, "R4", 64'(wave_rdy), 64'd0);
         pwr_smp = ~V_PWR[i];
         ch1_smp = ~V_CH1[i];
         ch2_smp = ~V_CH2[i];
         @(negedge clk);
         check(wave_reg == held, "R4", 64'(wave_reg), 64'(held));
         wait_rdy(n);
         check(n + 2 == per, "R2", 64'(n + 2), 64'(per));
         check(wave_reg == exp_word(V_SRC[i], ~V_PWR[i], ~V_CH1[i], ~V_CH2[i]),
               src_tag(V_SRC[i]), 64'(wave_reg),
               64'(exp_word(V_SRC[i], ~V_PWR[i], ~V_CH1[i], ~V_CH2[i])));
         prev_rate = V_RATE[i];
      end

      // R3: rate change in the middle of a period restarts the count
      @(negedge clk);
      rate_sel = 2'd2;
      repeat (40) @(negedge clk);
      rate_sel = 2'd0;
      wait_rdy(n);
      check(n == 129, "R3", 64'(n), 64'd129);

      // R1: mid-run reset clears everything, then restarts from zero
      @(negedge clk);
      rst_n = 1'b0;
      rate_sel = 2'd0;
      src_sel = 2'd1;
      @(negedge clk);
      check(wave_reg == '0 && wave_len == '0 && wave_rdy == 1'b0, "R1",
            {wave_reg, wave_len, 17'(wave_rdy)}, 64'd0);
      rst_n = 1'b1;
      wait_rdy(n);
      check(n == 128, "R1", 64'(n), 64'd128);
      check(wave_len == 6'd40, "R7", 64'(wave_len), 64'd40);

      finish_run();
   end
endmodule